// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block produces horizontal sync, vertical sync, data-enable and active-area pixel coordinates for a raster display. The lengths of every segment come from software, in pixel clocks for the horizontal axis and in lines for the vertical axis. Software writes timing words through a plain address, data and write-strobe port into a shadow bank. Those words have no effect until software requests an upload. The upload waits for the end of the current frame, so every frame is drawn with one consistent set of values.

A control word sets a delay, in pixel clocks, applied to the vertical sync output only. The same word carries two output-format flags, which the block presents as steady outputs for the downstream pixel path. A line runs sync, back porch, active, front porch. A frame runs through the same four segments, counted in lines. Sync outputs are active high.

Top module: `video_timing_gen`

## Requirements
- R1: While `rst` is high and on the first edge after it, all outputs are 0. Reset loads zero into every shadow and working word, so each segment is one unit long and both the line and the frame are 4 units.
- R2: Word addresses: 0 is horizontal {back porch [31:16], sync [15:0]}. 1 is horizontal {front porch [31:16], active [15:0]}. 2 and 3 use the same layout for the vertical axis, counted in lines. 4 is control {vsync delay [29:20], 24-bit format flag [8], 18-bit format flag [0]}. 5 is upload, with the request in bit 0.
- R3: A line is sync, then back porch, then active, then front porch, with a period equal to the sum of the four lengths. `hsync_o` is high for the first sync-length clocks of each line.
- R4: A frame is the same four segments counted in whole lines. The undelayed vertical sync is high for the first sync-length lines.
- R5: `de_o` is high only when the horizontal and the vertical positions are both inside their active segments. During that time, `pix_x_o` and `pix_y_o` give the zero-based active column and row. Outside it, both read 0.
- R6: A length field of zero acts as a length of one clock, or one line.
- R7: Writes to words 0 to 4 change nothing at the outputs until an upload is applied. A write to word 5 with bit 0 clear is ignored.
- R8: An upload request is held pending. It is applied on the clock edge that ends the last pixel of the current frame, copying all five shadow words as they are at that edge into the working set. It then clears itself. A request written on that same edge waits for the following frame end.
- R9: `vsync_o` is the undelayed vertical sync shifted later by D pixel clocks, where D is the working delay field (0 to 1023), keeping its alignment to `hsync_o`. Before D clocks have passed since reset, the delayed output is 0.
- R10: `fmt24_o` and `fmt18_o` follow bits 8 and 0 of the working control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (3) | Register word address |
| wr_data | input | 32 | Register write data |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Delayed vertical sync, active high |
| de_o | output | 1 | Data enable |
| pix_x_o | output | TW (16) | Active column, 0 outside the active area |
| pix_y_o | output | TW (16) | Active row, 0 outside the active area |
| fmt24_o | output | 1 | 24-bit format flag from the working control word |
| fmt18_o | output | 1 | 18-bit format flag from the working control word |

## Verification
`hsync_o`, `de_o`, `pix_x_o`, `pix_y_o` and the format flags are all registered once. Each shows, one edge later, the raster position and working set that held just before that edge. `vsync_o` arrives D edges after that. A committed upload is seen first on the edge after the frame-end edge.

The bench model follows the same per-edge rule. It uses the working values held before each edge, applies the frame-end upload before that edge's register write, and keeps a history of undelayed vertical sync values to produce the delayed one. The outputs are sampled on the falling edge, away from the edge that moves them.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned NUM_WORDS = 5;
  localparam int unsigned HI_LSB    = 16;
  localparam int unsigned DLY_LSB   = 20;
  localparam int unsigned FMT24_BIT = 8;
  localparam int unsigned FMT18_BIT = 0;
  localparam int unsigned UPLD_BIT  = 0;

  typedef enum logic [2:0] {
    REG_HA   = 3'd0,
    REG_HB   = 3'd1,
    REG_VA   = 3'd2,
    REG_VB   = 3'd3,
    REG_CTRL = 3'd4,
    REG_UPLD = 3'd5
  } vtg_reg_e;
endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
  import vtg_pkg::*;
#(
  parameter int unsigned TW = 16,
  parameter int unsigned DW = 10,
  parameter int unsigned AW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              frame_end,
  output logic [TW-1:0]     h_sync,
  output logic [TW-1:0]     h_bp,
  output logic [TW-1:0]     h_act,
  output logic [TW-1:0]     h_fp,
  output logic [TW-1:0]     v_sync,
  output logic [TW-1:0]     v_bp,
  output logic [TW-1:0]     v_act,
  output logic [TW-1:0]     v_fp,
  output logic [DW-1:0]     vs_dly,
  output logic              fmt24,
  output logic              fmt18
);
  logic [WORD_W-1:0] shadow_q [NUM_WORDS];
  logic [WORD_W-1:0] work_q   [NUM_WORDS];
  logic              pending_q;

  logic upld_wr;
  logic apply;
  assign upld_wr = wr_en && (wr_addr == AW'(REG_UPLD)) && wr_data[UPLD_BIT];
  assign apply   = frame_end && pending_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_WORDS; i++) begin
        shadow_q[i] <= '0;
        work_q[i]   <= '0;
      end
      pending_q <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_WORDS; i++) begin
        if (apply) work_q[i] <= shadow_q[i];
        if (wr_en && (wr_addr == AW'(i))) shadow_q[i] <= wr_data;
      end
      if (upld_wr)    pending_q <= 1'b1;
      else if (apply) pending_q <= 1'b0;
    end
  end

  function automatic logic [TW-1:0] eff_len(input logic [TW-1:0] f);
    return (f == '0) ? TW'(1) : f;
  endfunction

  assign h_sync = eff_len(work_q[int'(REG_HA)][TW-1:0]);
  assign h_bp   = eff_len(work_q[int'(REG_HA)][HI_LSB +: TW]);
  assign h_act  = eff_len(work_q[int'(REG_HB)][TW-1:0]);
  assign h_fp   = eff_len(work_q[int'(REG_HB)][HI_LSB +: TW]);
  assign v_sync = eff_len(work_q[int'(REG_VA)][TW-1:0]);
  assign v_bp   = eff_len(work_q[int'(REG_VA)][HI_LSB +: TW]);
  assign v_act  = eff_len(work_q[int'(REG_VB)][TW-1:0]);
  assign v_fp   = eff_len(work_q[int'(REG_VB)][HI_LSB +: TW]);
  assign vs_dly = work_q[int'(REG_CTRL)][DLY_LSB +: DW];
  assign fmt24  = work_q[int'(REG_CTRL)][FMT24_BIT];
  assign fmt18  = work_q[int'(REG_CTRL)][FMT18_BIT];

  logic unused_bits;
  assign unused_bits = ^{work_q[0], work_q[1], work_q[2], work_q[3], work_q[4]};

  // R8: the working set moves only on the edge that ends a frame
  p_hold_work_r8: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> ($stable(work_q[0]) && $stable(work_q[1]) && $stable(work_q[2])
                    && $stable(work_q[3]) && $stable(work_q[4])));

  // R8: an applied request clears itself unless re-requested on that edge
  p_req_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (apply && !upld_wr) |=> !pending_q);

  // R7: an upload write with the request bit clear leaves no request behind
  p_req_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_addr == AW'(REG_UPLD)) && !wr_data[UPLD_BIT] && !pending_q)
    |=> !pending_q);
endmodule

// File: rtl/vtg_axis.sv
module vtg_axis #(
  parameter int unsigned TW = 16,
  localparam int unsigned CW = TW + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [TW-1:0] len_sync,
  input  logic [TW-1:0] len_bp,
  input  logic [TW-1:0] len_act,
  input  logic [TW-1:0] len_fp,
  output logic          last,
  output logic          in_sync,
  output logic          in_act,
  output logic [TW-1:0] act_pos
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] act_start;
  logic [CW-1:0] act_end;
  logic [CW-1:0] total;

  assign act_start = CW'(len_sync) + CW'(len_bp);
  assign act_end   = act_start + CW'(len_act);
  assign total     = act_end + CW'(len_fp);

  assign last    = (cnt_q == total - CW'(1));
  assign in_sync = (cnt_q < CW'(len_sync));
  assign in_act  = (cnt_q >= act_start) && (cnt_q < act_end);
  assign act_pos = TW'(cnt_q - act_start);

  always_ff @(posedge clk) begin
    if (rst)      cnt_q <= '0;
    else if (adv) cnt_q <= last ? '0 : cnt_q + CW'(1);
  end

  // R3: the position never runs past the programmed period
  p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_q < total);
endmodule

// File: rtl/vtg_vs_delay.sv
module vtg_vs_delay #(
  parameter int unsigned DW = 10,
  localparam int unsigned DEPTH = 1 << DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          raw,
  input  logic [DW-1:0] dly,
  output logic          vs_o
);
  logic          hist_mem [DEPTH];
  logic [DW-1:0] wptr_q;
  logic [DW:0]   age_q;
  logic [DW-1:0] rd_addr;
  logic          filled;

  assign rd_addr = wptr_q - dly;
  assign filled  = (age_q >= {1'b0, dly});

  always_ff @(posedge clk) begin
    hist_mem[wptr_q] <= raw;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q <= '0;
      age_q  <= '0;
      vs_o   <= 1'b0;
    end else begin
      wptr_q <= wptr_q + DW'(1);
      if (!age_q[DW]) age_q <= age_q + (DW+1)'(1);
      if (dly == '0)   vs_o <= raw;
      else if (filled) vs_o <= hist_mem[rd_addr];
      else             vs_o <= 1'b0;
    end
  end
endmodule

// File: rtl/video_timing_gen.sv
module video_timing_gen
  import vtg_pkg::*;
#(
  parameter int unsigned TW = 16,
  parameter int unsigned DW = 10,
  parameter int unsigned AW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic [TW-1:0]     pix_x_o,
  output logic [TW-1:0]     pix_y_o,
  output logic              fmt24_o,
  output logic              fmt18_o
);
  logic [TW-1:0] h_sync, h_bp, h_act, h_fp;
  logic [TW-1:0] v_sync, v_bp, v_act, v_fp;
  logic [DW-1:0] vs_dly;
  logic          fmt24, fmt18;
  logic          h_last, h_in_sync, h_in_act;
  logic          v_last, v_in_sync, v_in_act;
  logic [TW-1:0] h_pos, v_pos;
  logic          frame_end;
  logic          active;

  assign frame_end = h_last && v_last;
  assign active    = h_in_act && v_in_act;

  vtg_regs #(.TW(TW), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_end(frame_end),
    .h_sync(h_sync), .h_bp(h_bp), .h_act(h_act), .h_fp(h_fp),
    .v_sync(v_sync), .v_bp(v_bp), .v_act(v_act), .v_fp(v_fp),
    .vs_dly(vs_dly), .fmt24(fmt24), .fmt18(fmt18)
  );

  vtg_axis #(.TW(TW)) u_h_axis (
    .clk(clk), .rst(rst), .adv(1'b1),
    .len_sync(h_sync), .len_bp(h_bp), .len_act(h_act), .len_fp(h_fp),
    .last(h_last), .in_sync(h_in_sync), .in_act(h_in_act), .act_pos(h_pos)
  );

  vtg_axis #(.TW(TW)) u_v_axis (
    .clk(clk), .rst(rst), .adv(h_last),
    .len_sync(v_sync), .len_bp(v_bp), .len_act(v_act), .len_fp(v_fp),
    .last(v_last), .in_sync(v_in_sync), .in_act(v_in_act), .act_pos(v_pos)
  );

  vtg_vs_delay #(.DW(DW)) u_vs_delay (
    .clk(clk), .rst(rst), .raw(v_in_sync), .dly(vs_dly), .vs_o(vsync_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_o <= 1'b0;
      de_o    <= 1'b0;
      pix_x_o <= '0;
      pix_y_o <= '0;
      fmt24_o <= 1'b0;
      fmt18_o <= 1'b0;
    end else begin
      hsync_o <= h_in_sync;
      de_o    <= active;
      pix_x_o <= active ? h_pos : '0;
      pix_y_o <= active ? v_pos : '0;
      fmt24_o <= fmt24;
      fmt18_o <= fmt18;
    end
  end

  // R5: the active segment never overlaps the sync segment of a line
  p_de_not_in_sync_r5: assert property (@(posedge clk) disable iff (rst)
    de_o |-> !hsync_o);
endmodule

// File: tb/test_video_timing_gen.sv
module test_video_timing_gen;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 16;
  localparam int DW = 10;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic          hsync_o, vsync_o, de_o, fmt24_o, fmt18_o;
  logic [TW-1:0] pix_x_o, pix_y_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  video_timing_gen #(.TW(TW), .DW(DW), .AW(AW)) i_video_timing_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .pix_x_o(pix_x_o), .pix_y_o(pix_y_o), .fmt24_o(fmt24_o), .fmt18_o(fmt18_o)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string scen = "R1";
  bit    started = 0;
  bit    done = 0;

  // behavioural reference
  logic [31:0] sh [5];
  logic [31:0] wk [5];
  bit          pend;
  int          pos;
  bit          hist [$];
  int exp_hs, exp_vs, exp_de, exp_px, exp_py, exp_f24, exp_f18;

  function automatic int eff(input logic [15:0] f);
    return (f == 16'd0) ? 1 : int'(f);
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      for (int i = 0; i < 5; i++) begin sh[i] = '0; wk[i] = '0; end
      pend = 0; pos = 0; hist.delete();
      exp_hs = 0; exp_vs = 0; exp_de = 0; exp_px = 0; exp_py = 0;
      exp_f24 = 0; exp_f18 = 0;
    end else begin
      int hs, hb, ha, hf, vs, vb, va, vf, ht, vt, x, y, d;
      bit raw, hin, vin;
      hs = eff(wk[0][15:0]); hb = eff(wk[0][31:16]);
      ha = eff(wk[1][15:0]); hf = eff(wk[1][31:16]);
      vs = eff(wk[2][15:0]); vb = eff(wk[2][31:16]);
      va = eff(wk[3][15:0]); vf = eff(wk[3][31:16]);
      ht = hs + hb + ha + hf; vt = vs + vb + va + vf;
      x = pos % ht; y = pos / ht;
      hin = (x >= hs + hb) && (x < hs + hb + ha);
      vin = (y >= vs + vb) && (y < vs + vb + va);
      raw = (y < vs);
      d = int'(wk[4][29:20]);
      exp_hs = (x < hs) ? 1 : 0;
      exp_de = (hin && vin) ? 1 : 0;
      exp_px = (hin && vin) ? x - hs - hb : 0;
      exp_py = (hin && vin) ? y - vs - vb : 0;
      exp_f24 = int'(wk[4][8]);
      exp_f18 = int'(wk[4][0]);
      if (d == 0) exp_vs = int'(raw);
      else if (hist.size() >= d) exp_vs = int'(hist[hist.size() - d]);
      else exp_vs = 0;
      hist.push_back(raw);
      if (hist.size() > 1024) void'(hist.pop_front());
      pos = pos + 1;
      if (pos == ht * vt) begin
        pos = 0;
        if (pend) begin
          for (int i = 0; i < 5; i++) wk[i] = sh[i];
          pend = 0;
        end
      end
      if (wr_en) begin
        if (wr_addr < 3'd5) sh[wr_addr] = wr_data;
        else if (wr_addr == 3'd5 && wr_data[0]) pend = 1;
      end
    end
  end

  task automatic chk(input string what, input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s (scenario %s) at %0t: actual %0d expected %0d",
               req, what, scen, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      if (rst) begin
        chk("hsync in reset", "R1", int'(hsync_o), 0);
        chk("vsync in reset", "R1", int'(vsync_o), 0);
        chk("de in reset", "R1", int'(de_o), 0);
        chk("pix in reset", "R1", int'(pix_x_o) + int'(pix_y_o), 0);
      end else begin
        chk("hsync", "R3", int'(hsync_o), exp_hs);
        chk("vsync", "R9", int'(vsync_o), exp_vs);
        chk("de", "R5", int'(de_o), exp_de);
        chk("pix_x", "R5", int'(pix_x_o), exp_px);
        chk("pix_y", "R5", int'(pix_y_o), exp_py);
        chk("fmt24", "R10", int'(fmt24_o), exp_f24);
        chk("fmt18", "R10", int'(fmt18_o), exp_f18);
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] pk(input int hi, input int lo);
    return {hi[15:0], lo[15:0]};
  endfunction

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    scen = "R1 R6 defaults";
    run(40);

    scen = "R2 R3 R4";
    wr(0, pk(2, 3)); wr(1, pk(4, 8)); wr(2, pk(1, 2)); wr(3, pk(2, 4));
    wr(4, 32'h0); wr(5, 32'h1);
    run(400);

    scen = "R7 shadow only";
    wr(0, pk(5, 5)); wr(1, pk(1, 1)); wr(4, 32'h0000_0101);
    run(300);
    scen = "R7 upload bit clear";
    wr(5, 32'h2);
    run(300);

    scen = "R6 R8 zero fields";
    wr(0, pk(0, 0)); wr(1, pk(0, 5)); wr(2, pk(2, 0)); wr(3, pk(0, 3));
    wr(4, 32'h0);
    wr(5, 32'h1);
    run(200);

    scen = "R9 R10 delay 7";
    wr(0, pk(2, 3)); wr(1, pk(4, 8)); wr(2, pk(1, 2)); wr(3, pk(2, 4));
    wr(4, 32'h0070_0100); wr(5, 32'h1);
    run(500);
    scen = "R9 R10 delay 30";
    wr(4, 32'h01E0_0001); wr(5, 32'h1);
    run(500);
    scen = "R9 delay 1023";
    wr(4, 32'h3FF0_0000); wr(5, 32'h1);
    run(3000);
    scen = "R9 delay 0";
    wr(4, 32'h0); wr(5, 32'h1);
    run(300);

    scen = "R8 repeated request";
    wr(5, 32'h1); run(1); wr(5, 32'h1);
    wr(1, pk(3, 6));
    run(400);
    wr(3, pk(1, 2)); wr(5, 32'h1);
    run(400);

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      finish_run();
    end
  end
endmodule